// File: doc/BRIEF.md
# I2C Master Command and Status Register Front End

This block is the software-facing register layer of an I2C master. It holds the target address with its direction bit, the byte to transmit, and the byte last received. A command register turns writes into a single-cycle request to a byte-level bus engine. The request carries start, stop, direction, address and data fields, plus a flag that asks for a repeated START. The block reads back a status word with a busy flag, two error flags (address not acknowledged, data not acknowledged) and a flag that shows the bus is still held. It also keeps a raw NACK event flag that stays set until software clears it.

A command with START and RUN but no STOP leaves the bus held when the engine finishes. Software can then load a new address and issue START plus RUN again. The engine gets a restart request, and no STOP is sent in between. The two error flags clear when the status word is read, so one read both samples and acknowledges them. The raw NACK flag is not affected by status reads and is cleared by writing a one to it.

The engine is modelled as a plain handshake. The block sends a one-cycle request, and the engine later answers with a one-cycle done pulse that carries the acknowledge outcome and any received byte.

Top module: `i2cm_master_regs`

## Requirements
- R1: After a synchronous active-low reset, the following all read zero: status, target, received data and the raw NACK flag. No engine request is issued.
- R2: The register map is as follows.
  - Offset 0 is the target register: bits [6:0] hold the 7-bit address and bit 7 is the direction (1 = receive). It reads back as written.
  - Offset 1 takes the transmit byte on a write and returns the received byte on a read.
  - Offset 2 takes commands on a write: bit0 RUN, bit1 START, bit2 STOP. A read returns status: bit0 BUSY, bit1 ADDR_NACK, bit2 DATA_NACK, bit3 HELD.
  - Offset 3 returns the raw NACK flag in bit0.
  - Read data appears on the cycle after the read strobe.
- R3: A command write with RUN=1 while BUSY=0 is accepted. On the next cycle, eng_req_o pulses for one cycle. The request fields are: START and STOP taken from the command, direction and address taken from the target register, and the transmit byte. BUSY then reads 1.
- R4: A command write while BUSY=1, or a command write with RUN=0, is ignored. No request is issued and the status is unchanged.
- R5: A done pulse while BUSY=1 clears BUSY. HELD becomes 1 if the finished command had no STOP and no NACK was reported. Otherwise HELD becomes 0.
- R6: An accepted START command while HELD=1 raises eng_restart_o with the request. With HELD=0, eng_restart_o stays 0.
- R7: ADDR_NACK and DATA_NACK are set by a done pulse that reports the matching NACK. A status read returns their old values and clears them. A NACK reported in the same cycle as the read still leaves the bit set.
- R8: Any reported NACK sets the raw NACK flag. Status reads do not clear it. Writing 1 to bit0 of offset 3 clears it, and writing 0 there has no effect.
- R9: A receive transfer that completes without a NACK loads the engine's byte into the received-data register. A transmit transfer leaves that register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | 2 | Register offset |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data, valid one cycle after the read strobe |
| eng_req_o | output | 1 | One-cycle request to the byte engine |
| eng_start_o | output | 1 | Request begins with a START |
| eng_restart_o | output | 1 | START is a repeated START on a held bus |
| eng_stop_o | output | 1 | Request ends with a STOP |
| eng_rnw_o | output | 1 | Direction of the request, 1 = receive |
| eng_addr_o | output | 7 | Target address of the request |
| eng_txd_o | output | 8 | Byte to transmit |
| eng_done_i | input | 1 | Engine finished the request (one-cycle pulse) |
| eng_addr_nack_i | input | 1 | Address was not acknowledged (valid with done) |
| eng_data_nack_i | input | 1 | Data was not acknowledged (valid with done) |
| eng_rxd_i | input | 8 | Received byte (valid with done) |

## Verification
The bench builds the block with its default widths: an 8-bit data path, a 7-bit address and a 2-bit register offset. These cover every field position named in the requirements, including the direction bit sitting directly above the address. With these values the bench can reach every status combination. This includes a transmit that leaves the bus held and a receive issued as a repeated START. It also covers a done pulse that reports a NACK in the very cycle the status word is read, which shows that the set wins over the read-clear.

// File: rtl/i2cm_regs_pkg.sv
// Package: shared offsets, command bit positions and status layout for the
// I2C master register front end. Assumes a 2-bit register offset space.
package i2cm_regs_pkg;
    localparam int unsigned OFS_TARGET = 0;
    localparam int unsigned OFS_DATA   = 1;
    localparam int unsigned OFS_CMD    = 2;
    localparam int unsigned OFS_NACK   = 3;

    localparam int unsigned CMD_RUN    = 0;
    localparam int unsigned CMD_START  = 1;
    localparam int unsigned CMD_STOP   = 2;

    // Status word, least significant field last.
    typedef struct packed {
        logic held;
        logic dnack;
        logic anack;
        logic busy;
    } stat_t;
endpackage

// File: rtl/i2cm_cfg_regs.sv
// Module: holds the target address/direction, the transmit byte, and the
// last received byte. Assumes the done pulse is only passed in while a
// transfer is outstanding (qualified by the caller).
module i2cm_cfg_regs #(
    parameter int unsigned DATA_W  = 8,
    parameter int unsigned TADDR_W = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tgt_wr,
    input  logic               txd_wr,
    input  logic [DATA_W-1:0]  wdata,
    input  logic               done_v,
    input  logic               xfer_rnw,
    input  logic               any_nack,
    input  logic [DATA_W-1:0]  rxd_in,
    output logic [TADDR_W-1:0] taddr,
    output logic               tdir,
    output logic [DATA_W-1:0]  txd,
    output logic [DATA_W-1:0]  rxd
);
    // Target register: address and direction as written by software.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            taddr <= '0;
            tdir  <= 1'b0;
        end else if (tgt_wr) begin
            taddr <= wdata[TADDR_W-1:0];
            tdir  <= wdata[TADDR_W];
        end
    end

    // Transmit byte register.
    always_ff @(posedge clk) begin
        if (!rst_n)      txd <= '0;
        else if (txd_wr) txd <= wdata;
    end

    // Received byte: captured on a clean finish of a receive transfer.
    always_ff @(posedge clk) begin
        if (!rst_n)                              rxd <= '0;
        else if (done_v && xfer_rnw && !any_nack) rxd <= rxd_in;
    end
endmodule

// File: rtl/i2cm_cmd_ctrl.sv
// Module: accepts commands, tracks BUSY and bus-held state, and issues the
// one-cycle engine request with its fields. Assumes the engine answers each
// request with exactly one done pulse.
module i2cm_cmd_ctrl #(
    parameter int unsigned DATA_W  = 8,
    parameter int unsigned TADDR_W = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_wr,
    input  logic               cmd_run,
    input  logic               cmd_start,
    input  logic               cmd_stop,
    input  logic [TADDR_W-1:0] taddr,
    input  logic               tdir,
    input  logic [DATA_W-1:0]  txd,
    input  logic               done,
    input  logic               any_nack,
    output logic               busy,
    output logic               held,
    output logic               req,
    output logic               q_start,
    output logic               q_restart,
    output logic               q_stop,
    output logic               q_rnw,
    output logic [TADDR_W-1:0] q_addr,
    output logic [DATA_W-1:0]  q_txd
);
    logic accept;

    // Accept only a RUN command while idle.
    always_comb accept = cmd_wr && cmd_run && !busy;

    // Request pulse, BUSY/HELD tracking and latched request fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy      <= 1'b0;
            held      <= 1'b0;
            req       <= 1'b0;
            q_start   <= 1'b0;
            q_restart <= 1'b0;
            q_stop    <= 1'b0;
            q_rnw     <= 1'b0;
            q_addr    <= '0;
            q_txd     <= '0;
        end else begin
            req <= accept;
            if (accept) begin
                busy      <= 1'b1;
                q_start   <= cmd_start;
                q_restart <= cmd_start && held;
                q_stop    <= cmd_stop;
                q_rnw     <= tdir;
                q_addr    <= taddr;
                q_txd     <= txd;
            end else if (busy && done) begin
                busy <= 1'b0;
                held <= !(q_stop || any_nack);
            end
        end
    end
endmodule

// File: rtl/i2cm_err_flags.sv
// Module: keeps the read-clear ADDR_NACK/DATA_NACK flags and the
// write-one-clear raw NACK flag. A new NACK wins over a clear in the same cycle.
module i2cm_err_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic done_v,
    input  logic addr_nack,
    input  logic data_nack,
    input  logic stat_rd,
    input  logic ris_w1c,
    output logic anack,
    output logic dnack,
    output logic ris
);
    // Address NACK flag: set by engine, cleared by status read.
    always_ff @(posedge clk) begin
        if (!rst_n)                      anack <= 1'b0;
        else if (done_v && addr_nack)    anack <= 1'b1;
        else if (stat_rd)                anack <= 1'b0;
    end

    // Data NACK flag: set by engine, cleared by status read.
    always_ff @(posedge clk) begin
        if (!rst_n)                      dnack <= 1'b0;
        else if (done_v && data_nack)    dnack <= 1'b1;
        else if (stat_rd)                dnack <= 1'b0;
    end

    // Raw NACK event flag: set on any NACK, cleared only by write-one.
    always_ff @(posedge clk) begin
        if (!rst_n)                                  ris <= 1'b0;
        else if (done_v && (addr_nack || data_nack)) ris <= 1'b1;
        else if (ris_w1c)                            ris <= 1'b0;
    end
endmodule

// File: rtl/i2cm_master_regs.sv
// Module: top of the I2C master register front end. Decodes register
// accesses, registers read data, and joins the configuration, command and
// error-flag pieces. Assumes DATA_W > TADDR_W and DATA_W >= 4.
module i2cm_master_regs
    import i2cm_regs_pkg::*;
#(
    parameter int unsigned DATA_W  = 8,
    parameter int unsigned TADDR_W = 7,
    parameter int unsigned REG_AW  = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr_i,
    input  logic               reg_rd_i,
    input  logic [REG_AW-1:0]  reg_addr_i,
    input  logic [DATA_W-1:0]  reg_wdata_i,
    output logic [DATA_W-1:0]  reg_rdata_o,
    output logic               eng_req_o,
    output logic               eng_start_o,
    output logic               eng_restart_o,
    output logic               eng_stop_o,
    output logic               eng_rnw_o,
    output logic [TADDR_W-1:0] eng_addr_o,
    output logic [DATA_W-1:0]  eng_txd_o,
    input  logic               eng_done_i,
    input  logic               eng_addr_nack_i,
    input  logic               eng_data_nack_i,
    input  logic [DATA_W-1:0]  eng_rxd_i
);
    localparam int unsigned STAT_W = $bits(stat_t);

    logic sel_tgt, sel_dat, sel_cmd, sel_nck;
    logic busy, held, nack_ris, anack, dnack, done_v, any_nack;
    logic [TADDR_W-1:0] taddr;
    logic               tdir;
    logic [DATA_W-1:0]  txd, rxd, rd_mux;
    stat_t              stat;

    // Offset decode.
    always_comb begin
        sel_tgt = (reg_addr_i == REG_AW'(OFS_TARGET));
        sel_dat = (reg_addr_i == REG_AW'(OFS_DATA));
        sel_cmd = (reg_addr_i == REG_AW'(OFS_CMD));
        sel_nck = (reg_addr_i == REG_AW'(OFS_NACK));
    end

    // Engine completion qualified by an outstanding transfer.
    always_comb begin
        done_v   = eng_done_i && busy;
        any_nack = eng_addr_nack_i || eng_data_nack_i;
    end

    i2cm_cfg_regs #(.DATA_W(DATA_W), .TADDR_W(TADDR_W)) cfg_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .tgt_wr   (reg_wr_i && sel_tgt),
        .txd_wr   (reg_wr_i && sel_dat),
        .wdata    (reg_wdata_i),
        .done_v   (done_v),
        .xfer_rnw (eng_rnw_o),
        .any_nack (any_nack),
        .rxd_in   (eng_rxd_i),
        .taddr    (taddr),
        .tdir     (tdir),
        .txd      (txd),
        .rxd      (rxd)
    );

    i2cm_cmd_ctrl #(.DATA_W(DATA_W), .TADDR_W(TADDR_W)) ctl_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_wr    (reg_wr_i && sel_cmd),
        .cmd_run   (reg_wdata_i[CMD_RUN]),
        .cmd_start (reg_wdata_i[CMD_START]),
        .cmd_stop  (reg_wdata_i[CMD_STOP]),
        .taddr     (taddr),
        .tdir      (tdir),
        .txd       (txd),
        .done      (eng_done_i),
        .any_nack  (any_nack),
        .busy      (busy),
        .held      (held),
        .req       (eng_req_o),
        .q_start   (eng_start_o),
        .q_restart (eng_restart_o),
        .q_stop    (eng_stop_o),
        .q_rnw     (eng_rnw_o),
        .q_addr    (eng_addr_o),
        .q_txd     (eng_txd_o)
    );

    i2cm_err_flags err_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .done_v    (done_v),
        .addr_nack (eng_addr_nack_i),
        .data_nack (eng_data_nack_i),
        .stat_rd   (reg_rd_i && sel_cmd),
        .ris_w1c   (reg_wr_i && sel_nck && reg_wdata_i[0]),
        .anack     (anack),
        .dnack     (dnack),
        .ris       (nack_ris)
    );

    // Read multiplexer: selects the addressed register image.
    always_comb begin
        stat   = '{held: held, dnack: dnack, anack: anack, busy: busy};
        rd_mux = '0;
        if (sel_tgt)      rd_mux[TADDR_W:0]  = {tdir, taddr};
        else if (sel_dat) rd_mux             = rxd;
        else if (sel_cmd) rd_mux[STAT_W-1:0] = stat;
        else              rd_mux[0]          = nack_ris;
    end

    // Registered read data, updated on each read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)        reg_rdata_o <= '0;
        else if (reg_rd_i) reg_rdata_o <= rd_mux;
    end
endmodule

// File: rtl/i2cm_master_regs_chk.sv
// Checker: temporal properties of the I2C master register front end,
// attached to every instance of the top by bind.
module i2cm_master_regs_chk (
    input logic clk,
    input logic rst_n,
    input logic eng_req,
    input logic eng_start,
    input logic eng_restart,
    input logic eng_done,
    input logic addr_nack,
    input logic data_nack,
    input logic busy,
    input logic held,
    input logic nack_ris
);
    // R3: a request coincides with BUSY being set
    p_req_sets_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        eng_req |-> busy);

    // R3: a request follows an idle cycle and lasts one cycle
    p_req_from_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        eng_req |-> !$past(busy));
    p_req_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        eng_req |=> !eng_req);

    // R4: while busy and not finishing, no new request appears
    p_no_req_while_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !eng_done) |=> !eng_req);

    // R5: done clears BUSY
    p_done_clears_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && eng_done) |=> !busy);

    // R6: restart only with START on a held bus
    p_restart_needs_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_req && eng_restart) |-> (eng_start && $past(held)));

    // R8: any reported NACK sets the raw flag
    p_nack_sets_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && eng_done && (addr_nack || data_nack)) |=> nack_ris);
endmodule

bind i2cm_master_regs i2cm_master_regs_chk chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .eng_req     (eng_req_o),
    .eng_start   (eng_start_o),
    .eng_restart (eng_restart_o),
    .eng_done    (eng_done_i),
    .addr_nack   (eng_addr_nack_i),
    .data_nack   (eng_data_nack_i),
    .busy        (busy),
    .held        (held),
    .nack_ris    (nack_ris)
);

// File: tb/i2cm_master_regs_tb_top.sv
`timescale 1ns/1ps
// Bench: scoreboard for the I2C master register front end. Driver tasks
// push expected engine requests into a queue; a monitor pops and compares.
module i2cm_master_regs_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0, reg_rd = 1'b0;
    logic [1:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       eng_req, eng_start, eng_restart, eng_stop, eng_rnw;
    logic [6:0] eng_addr;
    logic [7:0] eng_txd;
    logic       eng_done = 1'b0, eng_anack = 1'b0, eng_dnack = 1'b0;
    logic [7:0] eng_rxd = '0;

    int n_chk = 0, n_bad = 0, cyc = 0;
    bit finished = 0;
    logic [18:0] exp_q[$];

    always #2.5 clk = ~clk;

    i2cm_master_regs dut_i (
        .clk(clk), .rst_n(rst_n),
        .reg_wr_i(reg_wr), .reg_rd_i(reg_rd), .reg_addr_i(reg_addr),
        .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
        .eng_req_o(eng_req), .eng_start_o(eng_start), .eng_restart_o(eng_restart),
        .eng_stop_o(eng_stop), .eng_rnw_o(eng_rnw), .eng_addr_o(eng_addr),
        .eng_txd_o(eng_txd), .eng_done_i(eng_done), .eng_addr_nack_i(eng_anack),
        .eng_data_nack_i(eng_dnack), .eng_rxd_i(eng_rxd)
    );

    task automatic check(input bit ok, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", what, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic rd_chk(input logic [1:0] a, input logic [7:0] exp, input string what);
        @(negedge clk); reg_rd = 1'b1; reg_addr = a;
        @(posedge clk); @(negedge clk); reg_rd = 1'b0;
        check(reg_rdata === exp, what, reg_rdata, exp);
    endtask

    task automatic expect_req(input bit s, input bit rs, input bit sp, input bit rnw,
                              input logic [6:0] a, input logic [7:0] d);
        exp_q.push_back({s, rs, sp, rnw, a, d});
    endtask

    task automatic finish_xfer(input bit an, input bit dn, input logic [7:0] rx);
        @(negedge clk); eng_done = 1'b1; eng_anack = an; eng_dnack = dn; eng_rxd = rx;
        @(posedge clk); @(negedge clk); eng_done = 1'b0; eng_anack = 1'b0; eng_dnack = 1'b0;
    endtask

    // Monitor: compares each engine request with the head of the queue.
    always @(negedge clk) begin
        if (rst_n && eng_req) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R4 unexpected engine request", {eng_start, eng_addr}, 0);
            end else begin
                logic [18:0] e;
                e = exp_q.pop_front();
                check({eng_start, eng_restart, eng_stop, eng_rnw, eng_addr, eng_txd} === e,
                      "R3/R6 request fields",
                      {eng_start, eng_restart, eng_stop, eng_rnw, eng_addr, eng_txd}, e);
            end
        end
    end

    // Watchdog: ends a hung run as a failure.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !finished) begin
            finished = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual %0d expected below 20000 cycles", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        check(eng_req === 1'b0, "R1 no request after reset", eng_req, 0);
        rd_chk(2, 8'h00, "R1 status after reset");
        rd_chk(0, 8'h00, "R1 target after reset");
        rd_chk(1, 8'h00, "R1 rx data after reset");
        rd_chk(3, 8'h00, "R1 raw nack after reset");

        // Transmit without STOP: bus left held.
        wr(0, 8'h50);
        wr(1, 8'hA5);
        expect_req(1, 0, 0, 0, 7'h50, 8'hA5);
        wr(2, 8'h03);
        rd_chk(2, 8'h01, "R3 busy after accepted command");
        wr(2, 8'h07);
        rd_chk(2, 8'h01, "R4 command while busy ignored");
        finish_xfer(0, 0, 8'hEE);
        rd_chk(2, 8'h08, "R5 held after done without stop");
        rd_chk(1, 8'h00, "R9 transmit leaves rx data");

        // Repeated START, receive with STOP.
        wr(0, 8'hD1);
        rd_chk(0, 8'hD1, "R2 target readback");
        expect_req(1, 1, 1, 1, 7'h51, 8'hA5);
        wr(2, 8'h07);
        finish_xfer(0, 0, 8'h3C);
        rd_chk(2, 8'h00, "R5 bus released after stop");
        rd_chk(1, 8'h3C, "R9 rx data captured");

        // RUN=0 ignored.
        wr(2, 8'h02);
        repeat (3) @(negedge clk);
        rd_chk(2, 8'h00, "R4 command without run ignored");

        // Address NACK.
        wr(0, 8'h22);
        expect_req(1, 0, 0, 0, 7'h22, 8'hA5);
        wr(2, 8'h03);
        finish_xfer(1, 0, 8'h00);
        rd_chk(2, 8'h02, "R7 addr nack set, held cleared");
        rd_chk(3, 8'h01, "R8 raw nack set");
        rd_chk(2, 8'h00, "R7 addr nack cleared by read");
        rd_chk(3, 8'h01, "R8 raw nack survives status read");
        wr(3, 8'h01);
        rd_chk(3, 8'h00, "R8 raw nack cleared by write-one");
        rd_chk(1, 8'h3C, "R9 transmit keeps rx data");

        // Data NACK reported in the same cycle as a status read.
        wr(1, 8'h5A);
        expect_req(1, 0, 1, 0, 7'h22, 8'h5A);
        wr(2, 8'h07);
        @(negedge clk);
        eng_done = 1'b1; eng_dnack = 1'b1; reg_rd = 1'b1; reg_addr = 2'd2;
        @(posedge clk); @(negedge clk);
        eng_done = 1'b0; eng_dnack = 1'b0; reg_rd = 1'b0;
        check(reg_rdata === 8'h01, "R7 read returns value before nack", reg_rdata, 8'h01);
        rd_chk(2, 8'h04, "R7 data nack set wins over read clear");
        wr(3, 8'h00);
        rd_chk(3, 8'h01, "R8 writing zero keeps raw nack");
        wr(3, 8'h01);
        rd_chk(3, 8'h00, "R8 raw nack cleared");

        repeat (2) @(negedge clk);
        check(exp_q.size() == 0, "R3 all expected requests seen", exp_q.size(), 0);
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule